// File: doc/BRIEF.md
# Seconds and Nanoseconds Time-of-Day Counter

This block keeps wall-clock time as two registers: a 64-bit count of whole seconds and a 32-bit count of nanoseconds within the current second. It runs from the bus clock. On every clock edge it adds the bus clock period, given in nanoseconds as a parameter, to the nanoseconds register. When that sum reaches the rollover limit (one billion by default), the limit is subtracted and the seconds count steps by one.

Software reads the time through a small word-addressed register window. The seconds are read as an upper word and a lower word, and the nanoseconds as a third word. The three words are not captured together. To get a consistent value, software reads the lower seconds word, then the nanoseconds word, then the lower seconds word again, and repeats until both lower-word reads agree. Software sets the time by writing either seconds word. Each such write also restarts the nanoseconds from zero.

Top module: `tod_counter`

## Requirements
- R1: While reset is asserted, and on the first read after release, the seconds count and the nanoseconds count are both zero.
- R2: On every clock edge without a seconds write, if the nanoseconds value plus PERIOD_NS is below NS_LIMIT, the nanoseconds count increases by exactly PERIOD_NS and the seconds count holds.
- R3: If the nanoseconds value plus PERIOD_NS is equal to or greater than NS_LIMIT, the nanoseconds count becomes that sum minus NS_LIMIT and the seconds count increases by one. The nanoseconds count is never NS_LIMIT or more.
- R4: The seconds count is a single 64-bit value. A step past 0xFFFFFFFF in the lower word carries into the upper word.
- R5: A write to offset 0x24 loads write data into seconds bits 31:0 and keeps bits 63:32. The nanoseconds count is zero on the next cycle and counting resumes from there.
- R6: A write to offset 0x20 loads write data into seconds bits 63:32 and keeps bits 31:0. The nanoseconds count is zero on the next cycle.
- R7: Writes to offset 0x28, or to any offset other than 0x20 and 0x24, have no effect: counting continues as if no write took place.
- R8: The read data is combinational on the address. Offset 0x20 returns seconds bits 63:32, 0x24 returns seconds bits 31:0, 0x28 returns the nanoseconds count, and every other offset returns zero.
- R9: A seconds write in the same cycle as a nanoseconds rollover takes priority. The written word takes the write data, the other seconds word keeps its value without the increment, and the nanoseconds count becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; one edge advances time by PERIOD_NS |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte offset of the register word being read or written |
| wrEn | input | 1 | Write strobe for the word at addr |
| wrData | input | 32 | Data for a seconds word write |
| rdData | output | 32 | Contents of the word at addr |

## Verification
Four properties are checked on every cycle: the nanoseconds count stays below the limit, each plain step adds exactly the period while the seconds hold, each rollover subtracts the limit and adds one second, and each seconds write lands in the addressed word while leaving the other word alone and clearing the nanoseconds. Other behaviour can only be shown by the bench scenarios. This covers the carry out of the lower seconds word across the full 64-bit value, the read map including the zero returned for unused offsets, writes to read-only or unused offsets being ignored, and a write landing exactly on a rollover cycle. The bench shows these by comparing every word against arithmetic built from elapsed clock edges over thousands of consecutive cycles, in a configuration with a small rollover limit.

// File: rtl/tod_counter_pkg.sv
package tod_counter_pkg;

  localparam int unsigned OFS_SEC_HI = 32'h20;
  localparam int unsigned OFS_SEC_LO = 32'h24;
  localparam int unsigned OFS_NSEC   = 32'h28;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_HI   = 2'd1,
    SEL_LO   = 2'd2,
    SEL_NS   = 2'd3
  } readSel_e;

  typedef struct packed {
    logic     ldHi;
    logic     ldLo;
    readSel_e rdSel;
  } todStrobe_t;

endpackage

// File: rtl/tod_counter_ctrl.sv
module tod_counter_ctrl
  import tod_counter_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output todStrobe_t        strobe
);

  logic hitHi, hitLo, hitNs;

  assign hitHi = (addr == ADDR_W'(OFS_SEC_HI));
  assign hitLo = (addr == ADDR_W'(OFS_SEC_LO));
  assign hitNs = (addr == ADDR_W'(OFS_NSEC));

  always_comb begin
    strobe.ldHi  = wrEn && hitHi;
    strobe.ldLo  = wrEn && hitLo;
    if (hitHi)      strobe.rdSel = SEL_HI;
    else if (hitLo) strobe.rdSel = SEL_LO;
    else if (hitNs) strobe.rdSel = SEL_NS;
    else            strobe.rdSel = SEL_NONE;
  end

endmodule

// File: rtl/tod_counter_dp.sv
module tod_counter_dp
  import tod_counter_pkg::*;
#(
  parameter int PERIOD_NS = 5,
  parameter int NS_LIMIT  = 1000000000,
  parameter int WORD_W    = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  todStrobe_t          strobe,
  input  logic [WORD_W-1:0]   wrData,
  output logic [2*WORD_W-1:0] secVal,
  output logic [WORD_W-1:0]   nsVal,
  output logic [WORD_W-1:0]   rdData
);

  localparam int SecW = 2 * WORD_W;
  localparam int SumW = WORD_W + 1;

  logic [SecW-1:0]   secQ;
  logic [WORD_W-1:0] nsQ;
  logic [SumW-1:0]   nsSum;
  logic [SumW-1:0]   nsWrapped;
  logic              wrap;

  assign nsSum     = {1'b0, nsQ} + SumW'(PERIOD_NS);
  assign nsWrapped = nsSum - SumW'(NS_LIMIT);

  // When the period divides the limit the sum lands exactly on it,
  // so an equality compare is enough; otherwise compare magnitude.
  generate
    if (NS_LIMIT % PERIOD_NS == 0) begin : g_exactWrap
      assign wrap = (nsSum == SumW'(NS_LIMIT));
    end else begin : g_overWrap
      assign wrap = (nsSum >= SumW'(NS_LIMIT));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secQ <= '0;
      nsQ  <= '0;
    end else if (strobe.ldHi) begin
      secQ[SecW-1 -: WORD_W] <= wrData;
      nsQ <= '0;
    end else if (strobe.ldLo) begin
      secQ[WORD_W-1:0] <= wrData;
      nsQ <= '0;
    end else if (wrap) begin
      secQ <= secQ + SecW'(1);
      nsQ  <= nsWrapped[WORD_W-1:0];
    end else begin
      nsQ  <= nsSum[WORD_W-1:0];
    end
  end

  always_comb begin
    case (strobe.rdSel)
      SEL_HI:  rdData = secQ[SecW-1 -: WORD_W];
      SEL_LO:  rdData = secQ[WORD_W-1:0];
      SEL_NS:  rdData = nsQ;
      default: rdData = '0;
    endcase
  end

  assign secVal = secQ;
  assign nsVal  = nsQ;

endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_counter_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PERIOD_NS = 5,
  parameter int NS_LIMIT  = 1000000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData
);

  todStrobe_t  strobe;
  logic [63:0] secVal;
  logic [31:0] nsVal;

  tod_counter_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .addr   (addr),
    .wrEn   (wrEn),
    .strobe (strobe)
  );

  tod_counter_dp #(
    .PERIOD_NS (PERIOD_NS),
    .NS_LIMIT  (NS_LIMIT),
    .WORD_W    (32)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (wrData),
    .secVal (secVal),
    .nsVal  (nsVal),
    .rdData (rdData)
  );

endmodule

module tod_counter_chk #(
  parameter int ADDR_W    = 8,
  parameter int PERIOD_NS = 5,
  parameter int NS_LIMIT  = 1000000000
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic [31:0]       wrData,
  input logic [63:0]       secVal,
  input logic [31:0]       nsVal
);

  logic        pastOk;
  logic        ldHi, ldLo, anyLd;
  logic [63:0] nsStep;

  assign ldHi   = wrEn && (addr == ADDR_W'(32'h20));
  assign ldLo   = wrEn && (addr == ADDR_W'(32'h24));
  assign anyLd  = ldHi || ldLo;
  assign nsStep = 64'(nsVal) + 64'(PERIOD_NS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else        pastOk <= 1'b1;
  end

  // R3: nanoseconds never reach the limit
  a_r3_ns_below_limit: assert property (@(posedge clk) disable iff (!rstN)
    64'(nsVal) < 64'(NS_LIMIT));

  // R2: plain step adds the period, seconds hold
  a_r2_plain_step: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && !$past(anyLd) && ($past(nsStep) < 64'(NS_LIMIT)))
    |-> (64'(nsVal) == $past(nsStep)) && (secVal == $past(secVal)));

  // R3 and R4: rollover subtracts the limit and adds one second
  a_r3_rollover: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && !$past(anyLd) && ($past(nsStep) >= 64'(NS_LIMIT)))
    |-> (64'(nsVal) == $past(nsStep) - 64'(NS_LIMIT)) &&
        (secVal == $past(secVal) + 64'd1));

  // R5: lower word load
  a_r5_lo_load: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(ldLo))
    |-> (secVal[31:0] == $past(wrData)) &&
        (secVal[63:32] == $past(secVal[63:32])) && (nsVal == 32'd0));

  // R6: upper word load
  a_r6_hi_load: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(ldHi))
    |-> (secVal[63:32] == $past(wrData)) &&
        (secVal[31:0] == $past(secVal[31:0])) && (nsVal == 32'd0));

endmodule

bind tod_counter tod_counter_chk #(
  .ADDR_W    (ADDR_W),
  .PERIOD_NS (PERIOD_NS),
  .NS_LIMIT  (NS_LIMIT)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .addr   (addr),
  .wrEn   (wrEn),
  .wrData (wrData),
  .secVal (secVal),
  .nsVal  (nsVal)
);

// File: tb/tod_counter_tb.sv
`timescale 1ns/100ps
module tod_counter_tb;

  localparam int ADDR_W = 8;
  localparam int P      = 7;
  localparam int LIM    = 100;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              wrEn = 1'b0;
  logic [31:0]       wrData = '0;
  logic [31:0]       rdData;

  int unsigned       nChecks = 0;
  int unsigned       nFails = 0;
  bit                done = 1'b0;

  longint unsigned   baseSec = 0;
  longint unsigned   edges = 0;

  always #2.5 clk = ~clk;

  tod_counter #(.ADDR_W(ADDR_W), .PERIOD_NS(P), .NS_LIMIT(LIM)) u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData)
  );

  function automatic longint unsigned expSec();
    return baseSec + (edges * P) / LIM;
  endfunction

  function automatic longint unsigned expNs();
    return (edges * P) % LIM;
  endfunction

  task automatic cmp(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic readWord(input int unsigned ofs, output logic [31:0] val);
    addr = ADDR_W'(ofs);
    #0.4;
    val = rdData;
  endtask

  // R8: all three words compared against arithmetic model
  task automatic checkAll(input string tag);
    logic [31:0] v;
    longint unsigned s;
    s = expSec();
    readWord(32'h20, v); cmp(tag, "sec_hi", v, s[63:32]);
    readWord(32'h24, v); cmp(tag, "sec_lo", v, s[31:0]);
    readWord(32'h28, v); cmp(tag, "nsec",   v, 32'(expNs()));
    addr = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    edges++;
    @(negedge clk);
  endtask

  task automatic doWrite(input int unsigned ofs, input logic [31:0] d);
    longint unsigned cur;
    bit hit;
    cur = expSec();
    hit = 1'b1;
    if (ofs == 32'h20)      cur = {d, cur[31:0]};
    else if (ofs == 32'h24) cur = {cur[63:32], d};
    else                    hit = 1'b0;
    addr = ADDR_W'(ofs); wrData = d; wrEn = 1'b1;
    @(posedge clk);
    if (hit) begin baseSec = cur; edges = 0; end
    else edges++;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; addr = '0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    checkAll("R1");
    rstN = 1'b1;
    edges = 0; baseSec = 0;
    checkAll("R1");

    // R2 R3: long sweep through many rollovers
    for (int i = 0; i < 2000; i++) begin
      tick();
      checkAll("R2_R3");
    end

    // R4: carry from the lower into the upper seconds word
    doWrite(32'h20, 32'h1234_5678);
    checkAll("R6");
    doWrite(32'h24, 32'hFFFF_FFFF);
    checkAll("R5");
    for (int i = 0; i < 40; i++) begin
      tick();
      checkAll("R4");
    end
    doWrite(32'h20, 32'hFFFF_FFFF);
    doWrite(32'h24, 32'hFFFF_FFFF);
    for (int i = 0; i < 20; i++) begin
      tick();
      checkAll("R4_wrap64");
    end

    // R7: writes to read-only and unused offsets are ignored
    doWrite(32'h28, 32'h0000_0000);
    checkAll("R7_nsec");
    doWrite(32'h2C, 32'hDEAD_BEEF);
    checkAll("R7_unused");
    doWrite(32'h00, 32'h5555_5555);
    checkAll("R7_zero");
    doWrite(32'h1C, 32'hAAAA_AAAA);
    for (int i = 0; i < 5; i++) begin
      tick();
      checkAll("R7");
    end

    // R8: unused offsets read as zero
    readWord(32'h2C, v); cmp("R8", "ofs2C", v, 32'h0);
    readWord(32'h1C, v); cmp("R8", "ofs1C", v, 32'h0);
    readWord(32'h00, v); cmp("R8", "ofs00", v, 32'h0);
    addr = '0;

    // R9: load exactly on a rollover cycle (ns = 98, next sum 105)
    doWrite(32'h24, 32'h0000_0100);
    for (int i = 0; i < 14; i++) tick();
    cmp("R9", "pre_ns", 32'(expNs()), 32'd98);
    doWrite(32'h24, 32'h0000_0200);
    checkAll("R9_lo");
    for (int i = 0; i < 14; i++) tick();
    doWrite(32'h20, 32'h0000_0007);
    checkAll("R9_hi");
    for (int i = 0; i < 30; i++) begin
      tick();
      checkAll("R9_after");
    end

    // R1: reset again mid-run
    rstN = 1'b0;
    @(negedge clk);
    baseSec = 0; edges = 0;
    checkAll("R1_rerun");
    rstN = 1'b1;
    tick();
    checkAll("R2_rerun");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired got running expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule